// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel. Software controls it through a control/status word and four working registers: the link pointer, the source address, the target address and the command word. The channel runs in one of two ways. In direct mode, software writes the working registers and then sets the run bit. In chained mode, the channel reads four-word descriptors from memory into those registers and follows the link pointers. It stops after it finishes a descriptor whose link word has its stop flag set.

Data moves one burst at a time over a simple move-request port. A single request carries the source address, the target address and a byte count. The memory side performs the copy and acknowledges the request, with an optional error flag. Descriptor words are read over the same port as single-word fetches. Either side of a transfer can be paced by a peripheral request line. Completion, descriptor load and bus error are reported through sticky status bits. These bits also feed an interrupt output whose sources can be masked.

Top module: `dma_channel`

## Requirements
- R1: After reset the control/status word (register index 0) reads 0x00000008: only the stopped bit (bit 3) is set. `irq` is low and `memReq` is low. No memory request is issued while the channel is stopped.
- R2: In chained mode (bit 30 clear), setting run (bit 31) fetches four words from the link pointer (register index 1) with its low four bits cleared. The words are fetched at offsets 0, 4, 8 and 12 and go into the link, source, target and command registers in that order. When a descriptor finishes, the channel follows the new link. It halts instead when bit 1 of the link word is set. If bit 1 is already set when run is written, the channel halts without fetching anything.
- R3: Each move request carries a byte count of min(remaining length, burst size). The burst size is set by command bits 17:16: codes 1, 2 and 3 select 8, 16 and 32 bytes, and code 0 selects 8. Once raised, a request keeps its fields stable until `memAck`.
- R4: After each acknowledged burst, the source address advances by the bytes moved when command bit 31 is set. The target address does the same when bit 30 is set. A cleared bit leaves that address fixed.
- R5: The length field (command bits 12:0) drops by the bytes moved in each burst. When it reads zero, the end bit (bit 2) is set and the descriptor is complete. In direct mode the channel then halts.
- R6: `irq` is the OR of four terms: end AND command bit 21, start AND command bit 22, bus error, and stopped AND control bit 29.
- R7: The start bit (bit 1) is set each time a full four-word descriptor fetch succeeds.
- R8: Writing 1 to bit 2, bit 1 or bit 0 of the control/status word clears that sticky bit. Writing 0 leaves it unchanged. A hardware set in the same cycle wins.
- R9: When command bit 29 (source pacing) or bit 28 (target pacing) is set, no burst starts while that side's request input is low. Control bit 8 reads 1 while a paced side has its request high.
- R10: An error on a move acknowledge sets bus error (bit 0), clears run and stops the channel at once. The failed burst is not deducted from the length.
- R11: Writing 0 to run stops the channel at the next burst boundary, and the stopped bit then reads 1. When the channel halts on its own, the run bit clears itself.
- R12: Writes to register indices 1 to 4 (link, source, target, command) are ignored while the stopped bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index: 0 control/status, 1 link, 2 source, 3 target, 4 command |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| memReq | output | 1 | Memory request, held until acknowledged |
| memIsMove | output | 1 | 1 = burst move, 0 = descriptor word fetch |
| memAddr | output | 32 | Source address for moves, word address for fetches |
| memDstAddr | output | 32 | Target address of a move |
| memLen | output | 6 | Byte count of a move |
| memAck | input | 1 | Request completion |
| memErr | input | 1 | Error response, valid with `memAck` |
| memRdata | input | 32 | Fetched descriptor word, valid with `memAck` |
| srcPeriphReq | input | 1 | Source-side peripheral request |
| dstPeriphReq | input | 1 | Target-side peripheral request |
| irq | output | 1 | Interrupt request |

## Verification
A run bit written at one edge is seen by the controller at the next edge. The first request then rises one edge after that. Each acknowledged burst updates the addresses and the length on the acknowledging edge. Completion is flagged one edge later, in the check state, where run also clears. For this reason the bench never reads status at a fixed offset after the start. It waits two cycles and then polls the stopped bit. The scoreboard compares every move handshake at the falling edge of the acknowledge cycle, the only point where request and acknowledge are both high. Checks that a request is held back or ignored read the ports and registers after a wait of many cycles.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int DATA_W  = 32;
  localparam int LEN_W   = 13;
  localparam int CHUNK_W = 6;
  localparam int BASE_W  = DATA_W - 4;

  localparam logic [2:0] RA_CSR  = 3'd0;
  localparam logic [2:0] RA_NEXT = 3'd1;
  localparam logic [2:0] RA_SRC  = 3'd2;
  localparam logic [2:0] RA_DST  = 3'd3;
  localparam logic [2:0] RA_CMD  = 3'd4;

  localparam int C_RUN = 31, C_NODESC = 30, C_STOPIE = 29, C_REQPEND = 8;
  localparam int C_STOPPED = 3, C_END = 2, C_START = 1, C_ERR = 0;
  localparam int M_INCSRC = 31, M_INCDST = 30, M_FLOWSRC = 29, M_FLOWDST = 28;
  localparam int M_STARTIE = 22, M_ENDIE = 21, M_BURST_LO = 16;
  localparam int LINK_STOP = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER, ST_MOVE} chanState_e;

  typedef struct packed {
    logic       loadWord;
    logic [1:0] wordIdx;
    logic       moveDone;
    logic       setStart;
    logic       setEnd;
    logic       setErr;
    logic       clearRun;
  } chanStrobe_t;
endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    run,
  input  logic                    noDesc,
  input  logic                    stopFlag,
  input  logic [BASE_W-1:0]       nextBase,
  input  logic                    lenZero,
  input  logic                    flowOk,
  input  logic                    memAck,
  input  logic                    memErr,
  output chanStrobe_t             strobe,
  output logic                    memReq,
  output logic                    memIsMove,
  output logic [DATA_W-1:0]       fetchAddr,
  output logic                    stopped
);
  chanState_e stateQ, stateD;
  logic [1:0] wordIdxQ;
  logic [BASE_W-1:0] baseQ;
  logic enterFetch;

  always_comb begin
    strobe     = '0;
    memReq     = 1'b0;
    memIsMove  = 1'b0;
    stateD     = stateQ;
    enterFetch = 1'b0;
    fetchAddr  = {baseQ, wordIdxQ, 2'b00};
    strobe.wordIdx = wordIdxQ;
    unique case (stateQ)
      ST_IDLE: if (run) begin
        if (noDesc) stateD = ST_XFER;
        else if (stopFlag) strobe.clearRun = 1'b1;
        else begin stateD = ST_FETCH; enterFetch = 1'b1; end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strobe.setErr = 1'b1; strobe.clearRun = 1'b1; stateD = ST_IDLE;
          end else begin
            strobe.loadWord = 1'b1;
            if (wordIdxQ == 2'd3) begin strobe.setStart = 1'b1; stateD = ST_XFER; end
          end
        end
      end
      ST_XFER: begin
        if (!run) stateD = ST_IDLE;
        else if (lenZero) begin
          strobe.setEnd = 1'b1;
          if (noDesc || stopFlag) begin strobe.clearRun = 1'b1; stateD = ST_IDLE; end
          else begin stateD = ST_FETCH; enterFetch = 1'b1; end
        end else if (flowOk) stateD = ST_MOVE;
      end
      ST_MOVE: begin
        memReq = 1'b1;
        memIsMove = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strobe.setErr = 1'b1; strobe.clearRun = 1'b1; stateD = ST_IDLE;
          end else begin
            strobe.moveDone = 1'b1; stateD = ST_XFER;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      wordIdxQ <= 2'd0;
      baseQ    <= '0;
    end else begin
      stateQ <= stateD;
      if (enterFetch) begin
        baseQ    <= nextBase;
        wordIdxQ <= 2'd0;
      end else if (strobe.loadWord) begin
        wordIdxQ <= wordIdxQ + 2'd1;
      end
    end
  end

  assign stopped = (stateQ == ST_IDLE);
endmodule

// File: rtl/dma_chan_datapath.sv
module dma_chan_datapath
  import dma_chan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [2:0]           regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  chanStrobe_t          strobe,
  input  logic [DATA_W-1:0]    memRdata,
  input  logic                 stopped,
  input  logic                 srcPeriphReq,
  input  logic                 dstPeriphReq,
  output logic                 run,
  output logic                 noDesc,
  output logic                 stopFlag,
  output logic [BASE_W-1:0]    nextBase,
  output logic                 lenZero,
  output logic                 flowOk,
  output logic [DATA_W-1:0]    srcAddr,
  output logic [DATA_W-1:0]    dstAddr,
  output logic [CHUNK_W-1:0]   chunkLen,
  output logic                 irq
);
  logic [DATA_W-1:0] nextR, srcR, dstR, cmdR;
  logic runR, noDescR, stopIeR, endS, startS, errS;
  logic [LEN_W-1:0] lenR;
  logic [CHUNK_W-1:0] burstBytes;
  logic csrWr, reqPend;
  logic [DATA_W-1:0] csrView;

  assign csrWr = regWrEn && (regAddr == RA_CSR);
  assign lenR  = cmdR[LEN_W-1:0];

  always_comb begin
    unique case (cmdR[M_BURST_LO+1:M_BURST_LO])
      2'd2:    burstBytes = CHUNK_W'(16);
      2'd3:    burstBytes = CHUNK_W'(32);
      default: burstBytes = CHUNK_W'(8);
    endcase
  end

  assign chunkLen = (lenR < LEN_W'(burstBytes)) ? lenR[CHUNK_W-1:0] : burstBytes;
  assign reqPend  = (cmdR[M_FLOWSRC] & srcPeriphReq) | (cmdR[M_FLOWDST] & dstPeriphReq);
  assign flowOk   = (!cmdR[M_FLOWSRC] || srcPeriphReq) && (!cmdR[M_FLOWDST] || dstPeriphReq);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runR <= 1'b0; noDescR <= 1'b0; stopIeR <= 1'b0;
      endS <= 1'b0; startS <= 1'b0; errS <= 1'b0;
      nextR <= '0; srcR <= '0; dstR <= '0; cmdR <= '0;
    end else begin
      if (csrWr) begin
        runR    <= regWrData[C_RUN];
        noDescR <= regWrData[C_NODESC];
        stopIeR <= regWrData[C_STOPIE];
      end
      if (strobe.clearRun) runR <= 1'b0;
      endS   <= strobe.setEnd   | (endS   & ~(csrWr & regWrData[C_END]));
      startS <= strobe.setStart | (startS & ~(csrWr & regWrData[C_START]));
      errS   <= strobe.setErr   | (errS   & ~(csrWr & regWrData[C_ERR]));
      if (strobe.loadWord) begin
        unique case (strobe.wordIdx)
          2'd0: nextR <= memRdata;
          2'd1: srcR  <= memRdata;
          2'd2: dstR  <= memRdata;
          default: cmdR <= memRdata;
        endcase
      end else if (strobe.moveDone) begin
        if (cmdR[M_INCSRC]) srcR <= srcR + DATA_W'(chunkLen);
        if (cmdR[M_INCDST]) dstR <= dstR + DATA_W'(chunkLen);
        cmdR[LEN_W-1:0] <= lenR - LEN_W'(chunkLen);
      end else if (regWrEn && stopped) begin
        unique case (regAddr)
          RA_NEXT: nextR <= regWrData;
          RA_SRC:  srcR  <= regWrData;
          RA_DST:  dstR  <= regWrData;
          RA_CMD:  cmdR  <= regWrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    csrView            = '0;
    csrView[C_RUN]     = runR;
    csrView[C_NODESC]  = noDescR;
    csrView[C_STOPIE]  = stopIeR;
    csrView[C_REQPEND] = reqPend;
    csrView[C_STOPPED] = stopped;
    csrView[C_END]     = endS;
    csrView[C_START]   = startS;
    csrView[C_ERR]     = errS;
    unique case (regAddr)
      RA_NEXT: regRdData = nextR;
      RA_SRC:  regRdData = srcR;
      RA_DST:  regRdData = dstR;
      RA_CMD:  regRdData = cmdR;
      default: regRdData = csrView;
    endcase
  end

  assign run      = runR;
  assign noDesc   = noDescR;
  assign stopFlag = nextR[LINK_STOP];
  assign nextBase = nextR[DATA_W-1:4];
  assign lenZero  = (lenR == '0);
  assign srcAddr  = srcR;
  assign dstAddr  = dstR;
  assign irq = (endS & cmdR[M_ENDIE]) | (startS & cmdR[M_STARTIE]) | errS | (stopIeR & stopped);
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_chan_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               memReq,
  output logic               memIsMove,
  output logic [31:0]        memAddr,
  output logic [31:0]        memDstAddr,
  output logic [5:0]         memLen,
  input  logic               memAck,
  input  logic               memErr,
  input  logic [31:0]        memRdata,
  input  logic               srcPeriphReq,
  input  logic               dstPeriphReq,
  output logic               irq
);
  chanStrobe_t strobe;
  logic run, noDesc, stopFlag, lenZero, flowOk, stopped;
  logic [BASE_W-1:0] nextBase;
  logic [DATA_W-1:0] fetchAddr, srcAddr;

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .noDesc(noDesc), .stopFlag(stopFlag),
    .nextBase(nextBase), .lenZero(lenZero), .flowOk(flowOk),
    .memAck(memAck), .memErr(memErr), .strobe(strobe), .memReq(memReq),
    .memIsMove(memIsMove), .fetchAddr(fetchAddr), .stopped(stopped)
  );

  dma_chan_datapath u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .memRdata(memRdata), .stopped(stopped), .srcPeriphReq(srcPeriphReq),
    .dstPeriphReq(dstPeriphReq), .run(run), .noDesc(noDesc),
    .stopFlag(stopFlag), .nextBase(nextBase), .lenZero(lenZero),
    .flowOk(flowOk), .srcAddr(srcAddr), .dstAddr(memDstAddr),
    .chunkLen(memLen), .irq(irq)
  );

  assign memAddr = memIsMove ? srcAddr : fetchAddr;
endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memIsMove,
  input logic [31:0] memAddr,
  input logic [5:0]  memLen,
  input logic        memAck,
  input logic        memErr,
  input logic        stopped,
  input logic        flowOk
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopped |-> !memReq);

  // R3
  move_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memIsMove) |-> (memLen != 6'd0 && memLen <= 6'd32));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memIsMove) && $stable(memAddr)));

  // R9
  flow_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memIsMove && !$past(memReq && memIsMove)) |-> $past(flowOk));

  // R10
  err_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && memErr) |=> stopped);
endmodule

bind dma_channel dma_channel_chk u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memIsMove(memIsMove),
  .memAddr(memAddr), .memLen(memLen), .memAck(memAck), .memErr(memErr),
  .stopped(stopped), .flowOk(flowOk)
);

// File: tb/dma_channel_tb.sv
`timescale 1ns/1ps
module dma_channel_tb;
  typedef struct packed { logic [31:0] src; logic [31:0] dst; logic [5:0] len; } moveItem_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [31:0] regWrData = '0, regRdData;
  logic memReq, memIsMove, memAck = 1'b0, memErr = 1'b0;
  logic [31:0] memAddr, memDstAddr, memRdata = '0;
  logic [5:0] memLen;
  logic srcPeriphReq = 1'b0, dstPeriphReq = 1'b0;
  logic irq;

  int vecCnt = 0, missCnt = 0, moveCnt = 0, fetchCnt = 0, errAt = -1;
  int cycleCnt = 0;
  moveItem_t expQ[$];
  logic [31:0] dmem [64];
  logic [31:0] rd;

  always #4 clk = ~clk;

  dma_channel u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memIsMove(memIsMove), .memAddr(memAddr), .memDstAddr(memDstAddr),
    .memLen(memLen), .memAck(memAck), .memErr(memErr), .memRdata(memRdata),
    .srcPeriphReq(srcPeriphReq), .dstPeriphReq(dstPeriphReq), .irq(irq)
  );

  // memory responder: one-cycle acknowledge
  always @(posedge clk) begin
    memAck   <= memReq && !memAck;
    memRdata <= dmem[memAddr[7:2]];
    memErr   <= memReq && !memAck && memIsMove && (moveCnt == errAt);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && memReq && memAck) begin
      if (!memIsMove) fetchCnt++;
      else begin
        moveItem_t e;
        moveCnt++;
        vecCnt++;
        if (expQ.size() == 0) begin
          missCnt++;
          $display("FAIL R3 unexpected move act %h/%h/%0d exp none", memAddr, memDstAddr, memLen);
        end else begin
          e = expQ.pop_front();
          if (e !== {memAddr, memDstAddr, memLen}) begin
            missCnt++;
            $display("FAIL R3/R4 move act %h/%h/%0d exp %h/%h/%0d",
                     memAddr, memDstAddr, memLen, e.src, e.dst, e.len);
          end
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      missCnt++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic expectXfer(input logic [31:0] s, input logic [31:0] t, input int len,
                            input int burst, input bit incS, input bit incD);
    int left = len;
    while (left > 0) begin
      moveItem_t m;
      int c = (left < burst) ? left : burst;
      m.src = s; m.dst = t; m.len = 6'(c);
      expQ.push_back(m);
      if (incS) s = s + 32'(c);
      if (incD) t = t + 32'(c);
      left -= c;
    end
  endtask

  task automatic waitStopped();
    logic [31:0] v;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2000; i++) begin
      readReg(3'd0, v);
      if (v[3]) break;
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 100000) begin
      missCnt++;
      $display("FAIL watchdog act running exp done");
      finishRun();
    end
  end

  initial begin
    int mc;
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    // descriptor A at 0x40, descriptor B at 0x80
    dmem[16] = 32'h0000_0080; dmem[17] = 32'h0000_0100;
    dmem[18] = 32'h0000_0200; dmem[19] = 32'hC042_0018;
    dmem[32] = 32'h0000_0002; dmem[33] = 32'h0000_0300;
    dmem[34] = 32'h0000_0400; dmem[35] = 32'hC001_0008;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(3'd0, rd); check("R1 csr", rd, 32'h0000_0008);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 memReq", {31'd0, memReq}, 32'd0);

    // R3 R4 R5 direct mode, burst 8, both incrementing, end irq enabled
    writeReg(3'd2, 32'h0000_1000); writeReg(3'd3, 32'h0000_2000);
    writeReg(3'd4, 32'hC021_0014);
    expectXfer(32'h1000, 32'h2000, 20, 8, 1, 1);
    writeReg(3'd0, 32'hC000_0000);
    waitStopped();
    check("R3 queue drained", 32'(expQ.size()), 32'd0);
    readReg(3'd0, rd); check("R5 R11 csr after direct", rd, 32'h4000_000C);
    readReg(3'd4, rd); check("R5 length zero", {19'd0, rd[12:0]}, 32'd0);
    readReg(3'd2, rd); check("R4 src advanced", rd, 32'h0000_1014);
    check("R6 irq on end", {31'd0, irq}, 32'd1);
    writeReg(3'd0, 32'h0000_0004);
    readReg(3'd0, rd); check("R8 end cleared", rd, 32'h0000_0008);
    check("R8 irq low", {31'd0, irq}, 32'd0);

    // R3 R4 R6 burst 32, fixed target, end irq masked
    writeReg(3'd2, 32'h0000_3000); writeReg(3'd3, 32'h0000_5000);
    writeReg(3'd4, 32'h8003_0046);
    expectXfer(32'h3000, 32'h5000, 70, 32, 1, 0);
    writeReg(3'd0, 32'hC000_0000);
    waitStopped();
    check("R3 queue drained b32", 32'(expQ.size()), 32'd0);
    readReg(3'd3, rd); check("R4 dst fixed", rd, 32'h0000_5000);
    check("R6 irq masked", {31'd0, irq}, 32'd0);
    writeReg(3'd0, 32'h0000_0004);
    readReg(3'd0, rd); check("R8 zero write keeps", rd, 32'h0000_0008);

    // R2 R7 chained descriptors
    writeReg(3'd1, 32'h0000_0040);
    expectXfer(32'h100, 32'h200, 24, 16, 1, 1);
    expectXfer(32'h300, 32'h400, 8, 8, 1, 1);
    mc = fetchCnt;
    writeReg(3'd0, 32'h8000_0000);
    waitStopped();
    check("R2 queue drained chain", 32'(expQ.size()), 32'd0);
    check("R2 eight fetches", 32'(fetchCnt - mc), 32'd8);
    readReg(3'd0, rd); check("R7 start and end set", rd, 32'h0000_000E);
    readReg(3'd1, rd); check("R2 link loaded", rd, 32'h0000_0002);
    writeReg(3'd0, 32'h0000_0006);

    // R2 stop flag already set at start
    writeReg(3'd1, 32'h0000_0042);
    mc = fetchCnt;
    writeReg(3'd0, 32'h8000_0000);
    waitStopped();
    check("R2 no fetch on stop link", 32'(fetchCnt - mc), 32'd0);
    readReg(3'd0, rd); check("R2 R11 halted no start", rd, 32'h0000_0008);

    // R9 R12 source pacing
    srcPeriphReq = 1'b0;
    writeReg(3'd2, 32'h0000_0600); writeReg(3'd3, 32'h0000_0700);
    writeReg(3'd4, 32'hE001_0010);
    mc = moveCnt;
    writeReg(3'd0, 32'hC000_0000);
    repeat (20) @(negedge clk);
    check("R9 held while req low", 32'(moveCnt - mc), 32'd0);
    readReg(3'd0, rd); check("R9 csr blocked", rd, 32'hC000_0000);
    writeReg(3'd2, 32'hDEAD_0000);
    readReg(3'd2, rd); check("R12 write ignored", rd, 32'h0000_0600);
    expectXfer(32'h600, 32'h700, 16, 8, 1, 1);
    srcPeriphReq = 1'b1;
    readReg(3'd0, rd); check("R9 request pending", rd, 32'hC000_0100);
    waitStopped();
    check("R9 queue drained", 32'(expQ.size()), 32'd0);
    srcPeriphReq = 1'b0;
    writeReg(3'd0, 32'h0000_0004);

    // R11 software stop while target paced
    writeReg(3'd4, 32'hD001_0008);
    mc = moveCnt;
    writeReg(3'd0, 32'hC000_0000);
    repeat (5) @(negedge clk);
    writeReg(3'd0, 32'h4000_0000);
    @(negedge clk);
    readReg(3'd0, rd); check("R11 stopped by software", rd, 32'h4000_0008);
    check("R11 no moves", 32'(moveCnt - mc), 32'd0);

    // R10 bus error on second burst
    writeReg(3'd2, 32'h0000_0800); writeReg(3'd3, 32'h0000_0900);
    writeReg(3'd4, 32'hC001_0018);
    expectXfer(32'h800, 32'h900, 16, 8, 1, 1);
    errAt = moveCnt + 1;
    writeReg(3'd0, 32'hC000_0000);
    waitStopped();
    errAt = -1;
    check("R10 queue drained", 32'(expQ.size()), 32'd0);
    readReg(3'd0, rd); check("R10 error halt", rd, 32'h4000_0009);
    check("R10 R6 irq on error", {31'd0, irq}, 32'd1);
    readReg(3'd4, rd); check("R10 length kept", {19'd0, rd[12:0]}, 32'd16);
    writeReg(3'd0, 32'h0000_0001);
    check("R8 error cleared irq", {31'd0, irq}, 32'd0);

    // R6 stop interrupt enable
    writeReg(3'd0, 32'h2000_0000);
    check("R6 irq on stopped", {31'd0, irq}, 32'd1);
    writeReg(3'd0, 32'h0000_0000);
    check("R6 irq off", {31'd0, irq}, 32'd0);

    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule